// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is an eight-pin general-purpose I/O port for a small microcontroller core. Software reaches it through a simple byte-wide register bus with three locations: a latch that holds the drive values, a register that sets each pin's direction, and a read-only view of the pin levels. For every pin the port produces an output enable, a drive value and a weak pull-up enable for the pad.

A pin set as an output drives its latch bit push-pull, with the pull-up off. A pin set as an input floats, unless its latch bit is one. In that case the pull-up is turned on. Pin levels pass through a two-flop synchronizer before software can read them.

The top pin can be taken over by a serial-peripheral clock. In slave mode the pin is forced to be an input. Its pull-up stays under software control, and its level goes to the peripheral as a clock input. In master mode the peripheral's clock output takes the place of the latch bit as the drive value, and the direction bit still decides whether the pin drives.

Top module: `gpio_port`

## Requirements
- R1: Address decode uses a 6-bit address. The latch is at 0x18 and its alias 0x38. The direction register is at 0x17 and its alias 0x37. The pin view is at 0x16 and its alias 0x36. Reads are combinational, and any other address reads 0x00.
- R2: A write with `bus_we` high updates the addressed latch or direction register on the rising clock edge. Reading the latch returns the stored bits. Reading the direction register returns the stored direction bits.
- R3: A pin whose direction bit is 1 has `pad_oe`=1, `pad_out` equal to its drive value, and `pad_pu`=0.
- R4: A pin whose direction bit is 0 has `pad_oe`=0 and `pad_out`=0. Its `pad_pu` equals its latch bit.
- R5: Reading the pin view returns `pin_in` as it was two rising edges earlier.
- R6: Writes to the pin-view address leave the latch and the direction register unchanged.
- R7: An active-low `rst_n` clears the latch and the direction register at once, without waiting for a clock edge. All pins then have `pad_oe`=0 and `pad_pu`=0.
- R8: When `spi_en`=1 and `spi_master`=0, pin 7 has `pad_oe`=0 whatever its direction bit. In this mode `pad_pu[7]` equals latch bit 7, and `spi_sck_in` follows `pin_in[7]` combinationally.
- R9: When `spi_en`=1 and `spi_master`=1, direction bit 7 controls `pad_oe[7]` as usual, and `spi_sck_out` replaces latch bit 7 as the drive value.
- R10: When `spi_en`=0, pin 7 behaves like the other pins and `spi_sck_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Levels seen at the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| spi_en | input | 1 | Serial peripheral enabled |
| spi_master | input | 1 | Serial peripheral is master |
| spi_sck_out | input | 1 | Peripheral clock output in master mode |
| spi_sck_in | output | 1 | Pin 7 level given to the peripheral in slave mode |

## Verification
The pad controls are checked under a mixed direction and latch pattern, 0xF0 and 0xA5. This pattern contains all four combinations of direction and latch bit at once, so it separates push-pull high, push-pull low, pulled-up input and floating input. The same pattern is then run with the peripheral off, in slave mode and in master mode, with the peripheral clock held both high and low. This shows whether pin 7 takes its direction from the override or from software, and its drive value from the latch or from the peripheral.

The pin view is sampled one edge and two edges after `pin_in` changes, which pins down the synchronizer depth. Writes to the pin-view address, reads of unmapped addresses, and a mid-cycle reset then show that nothing else moves the registers.

// File: rtl/gpio_pkg.sv
// Package: shared sizes and register addresses for the GPIO port.
// Assumes a 6-bit register bus address space.
package gpio_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_LATCH  = 6'h18;
    localparam logic [ADDR_W-1:0] A_DIR    = 6'h17;
    localparam logic [ADDR_W-1:0] A_PINS   = 6'h16;
    localparam logic [ADDR_W-1:0] ALIAS_OF = 6'h20;

    typedef enum logic [1:0] {SEL_NONE, SEL_LATCH, SEL_DIR, SEL_PINS} reg_sel_e;

    // Map an address (base or alias) to a register select.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == A_LATCH || a == (A_LATCH | ALIAS_OF)) return SEL_LATCH;
        if (a == A_DIR   || a == (A_DIR   | ALIAS_OF)) return SEL_DIR;
        if (a == A_PINS  || a == (A_PINS  | ALIAS_OF)) return SEL_PINS;
        return SEL_NONE;
    endfunction
endpackage

// File: rtl/gpio_regs.sv
// Module: latch and direction registers.
// Assumes write enables are already decoded and one-hot; reset is async active-low.
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_latch,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    // Store software-written latch bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= wdata;
    end

    // Store software-written direction bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // R2: with no write strobe, both registers hold their values.
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_latch && !wr_dir) |=> ($stable(latch_q) && $stable(dir_q)));
    // R2: a latch write lands on the next edge.
    p_latch_takes_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> (latch_q == $past(wdata)));
endmodule

// File: rtl/gpio_sync.sv
// Module: two-flop synchronizer for the pad levels.
// Assumes pin levels are asynchronous to clk; output lags by two edges.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [1:0]   warm;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Count edges since reset so the check below looks back only within them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R5: the synchronized value is the pad level two edges back.
    p_two_edge_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin direction, drive and pull-up logic with a clock override on one pin.
// Assumes latch/direction come from gpio_regs; pull-up is only meaningful on inputs.
module gpio_pad_ctrl #(
    parameter int W       = 8,
    parameter int SCK_BIT = 7
) (
    input  logic         rst_n,
    input  logic         clk,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_in,
    input  logic         spi_en,
    input  logic         spi_master,
    input  logic         spi_sck_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu,
    output logic         spi_sck_in
);
    logic slave_mode;
    logic master_mode;

    // Classify the serial-peripheral mode.
    always_comb begin
        slave_mode  = spi_en && !spi_master;
        master_mode = spi_en &&  spi_master;
        spi_sck_in  = slave_mode ? pin_in[SCK_BIT] : 1'b0;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == SCK_BIT) begin : g_sck
            // Clock pin: direction may be forced, drive may come from the peripheral.
            always_comb begin
                pad_oe[i]  = slave_mode ? 1'b0 : dir_q[i];
                pad_out[i] = pad_oe[i] ? (master_mode ? spi_sck_out : latch_q[i]) : 1'b0;
                pad_pu[i]  = !pad_oe[i] && latch_q[i];
            end
        end else begin : g_plain
            // Plain pin: direction and drive straight from software.
            always_comb begin
                pad_oe[i]  = dir_q[i];
                pad_out[i] = dir_q[i] ? latch_q[i] : 1'b0;
                pad_pu[i]  = !dir_q[i] && latch_q[i];
            end
        end
    end

    // R8: slave mode never drives the clock pin.
    p_slave_releases_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> !pad_oe[SCK_BIT]);
    // R8: slave mode pull-up still follows software.
    p_slave_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (pad_pu[SCK_BIT] == latch_q[SCK_BIT]));
    // R9: master mode drives the peripheral clock when enabled as output.
    p_master_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master && dir_q[SCK_BIT]) |-> (pad_out[SCK_BIT] == spi_sck_out));
    // R3: no pin ever has pull-up and drive together.
    p_no_pullup_on_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);
endmodule

// File: rtl/gpio_port.sv
// Module: top of the 8-bit GPIO port; register decode, read mux and wiring.
// Assumes a single-cycle register bus with combinational reads.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W       = 8,
    parameter int SCK_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_we,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              spi_sck_out,
    output logic              spi_sck_in
);
    reg_sel_e     sel;
    logic         wr_latch, wr_dir;
    logic [W-1:0] latch_q, dir_q, pins_q;

    // Decode the address into write strobes.
    always_comb begin
        sel      = decode(bus_addr);
        wr_latch = bus_we && (sel == SEL_LATCH);
        wr_dir   = bus_we && (sel == SEL_DIR);
    end

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_latch(wr_latch), .wr_dir(wr_dir),
        .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_q)
    );

    gpio_pad_ctrl #(.W(W), .SCK_BIT(SCK_BIT)) u_pads (
        .rst_n(rst_n), .clk(clk), .latch_q(latch_q), .dir_q(dir_q), .pin_in(pin_in),
        .spi_en(spi_en), .spi_master(spi_master), .spi_sck_out(spi_sck_out),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .spi_sck_in(spi_sck_in)
    );

    // Select the read data for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_LATCH: bus_rdata = latch_q;
            SEL_DIR:   bus_rdata = dir_q;
            SEL_PINS:  bus_rdata = pins_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R6: a write aimed at the pin view leaves both registers untouched.
    p_pin_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && decode(bus_addr) == SEL_PINS) |=> ($stable(latch_q) && $stable(dir_q)));
    // R1: unmapped addresses read as zero.
    p_unmapped_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (decode(bus_addr) == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port.sv
// Scoreboard bench: driver pushes expectations, monitor pops and compares.
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata, pin_in, pad_oe, pad_out, pad_pu;
    logic       spi_en = 1'b0, spi_master = 1'b0, spi_sck_out = 1'b0, spi_sck_in;

    typedef enum int {K_RDATA, K_OE, K_OUT, K_PU, K_SCKIN} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t queue_q[$];
    event  probe;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .spi_en(spi_en), .spi_master(spi_master),
        .spi_sck_out(spi_sck_out), .spi_sck_in(spi_sck_in)
    );

    // Monitor: pop queued expectations and compare with the live outputs.
    initial begin
        forever begin
            @(probe);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = queue_q.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_OE:    act = pad_oe;
                    K_OUT:   act = pad_out;
                    K_PU:    act = pad_pu;
                    default: act = {7'd0, spi_sck_in};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input kind_e k, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        queue_q.push_back(it);
    endtask

    task automatic settle_and_probe();
        #1;
        -> probe;
        #1;
    endtask

    task automatic expect_read(input logic [5:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        push(K_RDATA, e, tag);
        settle_and_probe();
    endtask

    task automatic expect_pads(input logic [7:0] oe, input logic [7:0] o,
                               input logic [7:0] pu, input string tag);
        push(K_OE, oe, tag);
        push(K_OUT, o, tag);
        push(K_PU, pu, tag);
        settle_and_probe();
    endtask

    task automatic expect_sck(input logic v, input string tag);
        push(K_SCKIN, {7'd0, v}, tag);
        settle_and_probe();
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver: stimulus and expectations per requirement.
    initial begin
        pin_in = 8'h00;
        #3;
        expect_pads(8'h00, 8'h00, 8'h00, "R7 reset pads");
        expect_read(6'h18, 8'h00, "R7 reset latch");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        bus_write(6'h17, 8'hF0);
        bus_write(6'h18, 8'hA5);
        expect_read(6'h18, 8'hA5, "R2 latch readback");
        expect_read(6'h38, 8'hA5, "R1 latch alias");
        expect_read(6'h37, 8'hF0, "R1 R2 dir alias");
        expect_pads(8'hF0, 8'hA0, 8'h05, "R3 R4 mixed pattern");

        // R5: one edge later still old value, two edges later the new one.
        @(negedge clk);
        pin_in = 8'h3C;
        @(negedge clk);
        expect_read(6'h16, 8'h00, "R5 one edge");
        @(negedge clk);
        expect_read(6'h16, 8'h3C, "R5 two edges");
        expect_read(6'h36, 8'h3C, "R1 R5 pin alias");

        bus_write(6'h16, 8'hFF);
        bus_write(6'h36, 8'h00);
        expect_read(6'h18, 8'hA5, "R6 latch kept");
        expect_read(6'h17, 8'hF0, "R6 dir kept");
        expect_read(6'h10, 8'h00, "R1 unmapped");

        // R8: slave mode forces pin 7 to input.
        spi_en = 1'b1; spi_master = 1'b0;
        expect_pads(8'h70, 8'h20, 8'h85, "R8 slave pads");
        pin_in = 8'h80;
        expect_sck(1'b1, "R8 sck high");
        pin_in = 8'h00;
        expect_sck(1'b0, "R8 sck low");

        // R9: master mode drives peripheral clock.
        spi_master = 1'b1; spi_sck_out = 1'b1;
        expect_pads(8'hF0, 8'hA0, 8'h05, "R9 master clk high");
        spi_sck_out = 1'b0;
        expect_pads(8'hF0, 8'h20, 8'h05, "R9 master clk low");
        pin_in = 8'h80;
        expect_sck(1'b0, "R9 no sck in");

        // R10: peripheral off, pin 7 back under software.
        spi_en = 1'b0;
        expect_pads(8'hF0, 8'hA0, 8'h05, "R10 disabled pads");
        expect_sck(1'b0, "R10 sck in low");

        bus_write(6'h38, 8'h5A);
        expect_read(6'h18, 8'h5A, "R1 R2 write via alias");
        bus_write(6'h17, 8'hFF);
        bus_write(6'h18, 8'hFF);
        expect_pads(8'hFF, 8'hFF, 8'h00, "R3 all outputs");

        // R7: asynchronous reset between edges.
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        expect_pads(8'h00, 8'h00, 8'h00, "R7 async pads");
        expect_read(6'h17, 8'h00, "R7 async dir");
        expect_read(6'h18, 8'h00, "R7 async latch");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule